// File: doc/BRIEF.md
# Register Bit-Manipulation Unit

This block keeps one processor register, A, and rewrites its bits under control of an operand word B. Each operation is defined by what it does to the bits of A at the positions where B is 1 or 0. The set covers setting bits, inverting bits, clearing bits, keeping only masked bits, whole-word inversion, an equality compare that leaves A at zero on a match, and a two-step field insert.

A register update happens only on a rising clock edge where the enable input is 1, with one exception: the second step of an insert. A parallel load input writes A directly. A registered zero flag is updated together with A, so software-visible equality tests need no extra cycle.

The insert takes two clock edges. On the first edge, A is ANDed with B, where B has 0s over the field. On the second edge, A is ORed with the insert value, restricted to that field. While the second step is pending, the unit raises `busy` and ignores every other request.

Top module: `bitmanip_unit`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, `reg_a` becomes all zeros, `zero` becomes 1 and `busy` becomes 0.
- R2: With `busy` low and `en` low, a rising edge leaves `reg_a` and `zero` unchanged, whatever `op`, `ld` and `opnd_b` carry.
- R3: With `busy` low and both `en` and `ld` high, `reg_a` takes `ld_data`; `ld` has priority over `op`.
- R4: Code 3'b001 (set) makes `reg_a` = A | B.
- R5: Code 3'b010 (toggle) makes `reg_a` = A ^ B.
- R6: Code 3'b011 (clear) makes `reg_a` = A & ~B.
- R7: Code 3'b100 (mask) makes `reg_a` = A & B.
- R8: Code 3'b101 (invert) makes `reg_a` = ~A, and `opnd_b` has no effect.
- R9: Code 3'b110 (insert) makes `reg_a` = A & B on the accepting edge and raises `busy`. On the next edge, with no enable needed, `reg_a` becomes that value ORed with (`ins_val` & ~B), using the B and `ins_val` captured at acceptance; bits of `ins_val` outside the field have no effect.
- R10: While `busy` is 1, `en`, `ld` and `op` are ignored, and `busy` returns to 0 after the OR edge.
- R11: Code 3'b111 (compare) makes `reg_a` = A ^ B, so `zero` is 1 afterwards exactly when A equalled B.
- R12: After every update, `zero` is 1 exactly when the new `reg_a` is all zeros.
- R13: Code 3'b000 is unused and leaves `reg_a` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Enable (control variable) for an update |
| op | input | 3 | Operation code |
| opnd_b | input | WIDTH | Operand B; for insert, a keep-mask with 0s over the field |
| ins_val | input | WIDTH | Value written into the field by insert |
| ld | input | 1 | Parallel load request |
| ld_data | input | WIDTH | Parallel load data |
| reg_a | output | WIDTH | Register A |
| zero | output | 1 | Registered flag: A is all zeros |
| busy | output | 1 | Insert OR step pending |

## Verification
The assertions assume that inputs are stable at the rising edge and carry known values whenever `rst_n` is high. The bench meets this by driving every input on the falling edge and leaving no input undriven after reset. The insert properties look back to the accepting edge, which is always at least one cycle after reset, because `busy` can only rise from a request. The stimulus deliberately drives `en`, `ld` and `op` during the busy cycle so that the ignore rule is exercised, not merely assumed.

// File: rtl/bitmanip_pkg.sv
`timescale 1ns/1ps
// Package: shared operation encoding for the bit-manipulation unit.
// Assumes a 3-bit operation field; code 0 is reserved and acts as hold.
package bitmanip_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HOLD   = 3'd0,
        OP_SET    = 3'd1,
        OP_TOGGLE = 3'd2,
        OP_CLEAR  = 3'd3,
        OP_MASK   = 3'd4,
        OP_INVERT = 3'd5,
        OP_INSERT = 3'd6,
        OP_CMP    = 3'd7
    } op_t;
endpackage

// File: rtl/bm_bit_op.sv
`timescale 1ns/1ps
// Module: one bit stage. Computes the next value of a single bit of A
// from that bit, the matching bit of B and the shared operation code.
// Assumes: insert uses the mask step here; the OR step lives elsewhere.
module bm_bit_op
    import bitmanip_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  op_t  op_i,
    output logic y_o
);
    // Select the per-bit result for the current operation.
    always_comb begin
        case (op_i)
            OP_SET:    y_o = a_i | b_i;
            OP_TOGGLE: y_o = a_i ^ b_i;
            OP_CLEAR:  y_o = a_i & ~b_i;
            OP_MASK:   y_o = a_i & b_i;
            OP_INVERT: y_o = ~a_i;
            OP_INSERT: y_o = a_i & b_i;
            OP_CMP:    y_o = a_i ^ b_i;
            default:   y_o = a_i;
        endcase
    end
endmodule

// File: rtl/bm_insert_seq.sv
`timescale 1ns/1ps
// Module: insert sequencer. On start it captures the field value (the
// insert value limited to the 0s of the keep-mask) and holds busy for
// the single cycle before the OR step.
// Assumes: start is never raised while busy is high.
module bm_insert_seq #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] keep_i,
    input  logic [WIDTH-1:0] val_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] fill_o
);
    // Track the pending OR step and keep the captured field bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            fill_o <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            fill_o <= val_i & ~keep_i;
        end else begin
            busy_o <= 1'b0;
        end
    end
endmodule

// File: rtl/bitmanip_unit.sv
`timescale 1ns/1ps
// Module: register bit-manipulation unit (top). Holds register A and a
// zero flag, and applies bitwise operations with operand B when enabled.
// Insert is a two-edge mask-then-OR sequence with busy in between.
// Assumes: synchronous active-low reset; inputs are sampled at rising edges.
module bitmanip_unit
    import bitmanip_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] ins_val,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_data,
    output logic [WIDTH-1:0] reg_a,
    output logic             zero,
    output logic             busy
);
    localparam logic [WIDTH-1:0] ALL_ZERO = '0;

    op_t              op_q;
    logic             issue;
    logic             ins_start;
    logic             wr;
    logic [WIDTH-1:0] slice_y;
    logic [WIDTH-1:0] fill;
    logic [WIDTH-1:0] a_next;

    assign op_q      = op_t'(op);
    assign issue     = en && !busy;
    assign ins_start = issue && !ld && (op_q == OP_INSERT);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            bm_bit_op u_bit (
                .a_i  (reg_a[gi]),
                .b_i  (opnd_b[gi]),
                .op_i (op_q),
                .y_o  (slice_y[gi])
            );
        end
    endgenerate

    bm_insert_seq #(.WIDTH(WIDTH)) u_ins (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ins_start),
        .keep_i  (opnd_b),
        .val_i   (ins_val),
        .busy_o  (busy),
        .fill_o  (fill)
    );

    // Choose the next value of A: OR step, load, or bit-stage result.
    always_comb begin
        wr     = 1'b0;
        a_next = reg_a;
        if (busy) begin
            wr     = 1'b1;
            a_next = reg_a | fill;
        end else if (issue) begin
            wr     = 1'b1;
            a_next = ld ? ld_data : slice_y;
        end
    end

    // Register A and its zero flag together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a <= '0;
            zero  <= 1'b1;
        end else if (wr) begin
            reg_a <= a_next;
            zero  <= (a_next == ALL_ZERO);
        end
    end
endmodule

// File: rtl/bitmanip_chk.sv
`timescale 1ns/1ps
// Module: property checker for bitmanip_unit, attached by bind below.
// Assumes: inputs are known whenever rst_n is high.
module bitmanip_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [2:0]       op,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] ins_val,
    input logic             ld,
    input logic [WIDTH-1:0] ld_data,
    input logic [WIDTH-1:0] reg_a,
    input logic             zero,
    input logic             busy
);
    logic take;
    assign take = en && !busy && !ld;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> ($stable(reg_a) && $stable(zero)));

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !busy && ld) |=> (reg_a == $past(ld_data)));

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 3'd1) |=> (reg_a == ($past(reg_a) | $past(opnd_b))));

    // R8
    invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 3'd5) |=> (reg_a == ~$past(reg_a)));

    // R9
    insert_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == 3'd6) |=> (busy && reg_a == ($past(reg_a) & $past(opnd_b))));

    // R9
    insert_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (reg_a == ($past(reg_a) | ($past(ins_val, 2) & ~$past(opnd_b, 2)))));

    // R10
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R12
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (reg_a == '0));
endmodule

bind bitmanip_unit bitmanip_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .op      (op),
    .opnd_b  (opnd_b),
    .ins_val (ins_val),
    .ld      (ld),
    .ld_data (ld_data),
    .reg_a   (reg_a),
    .zero    (zero),
    .busy    (busy)
);

// File: tb/sim_bitmanip_unit.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, checking at the ports.
module sim_bitmanip_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] ins_val = '0;
    logic         ld = 1'b0;
    logic [W-1:0] ld_data = '0;
    logic [W-1:0] reg_a;
    logic         zero;
    logic         busy;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    bitmanip_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opnd_b(opnd_b),
        .ins_val(ins_val), .ld(ld), .ld_data(ld_data),
        .reg_a(reg_a), .zero(zero), .busy(busy)
    );

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge and sample after the rising edge.
    task automatic step(input logic e, input logic l, input logic [2:0] o,
                        input logic [W-1:0] b, input logic [W-1:0] v, input logic [W-1:0] d);
        @(negedge clk);
        en = e; ld = l; op = o; opnd_b = b; ins_val = v; ld_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [W-1:0] d);
        step(1'b1, 1'b0, 3'd0, '0, '0, '0);
        step(1'b1, 1'b1, 3'd5, 8'hFF, '0, d);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b1, 1'b1, 3'd1, 8'hFF, '0, 8'h55);
        check("R1 a", reg_a, 8'h00);
        check("R1 zero", {7'd0, zero}, 8'h01);
        check("R1 busy", {7'd0, busy}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_load_hold;
        step(1'b1, 1'b1, 3'd1, 8'hFF, '0, 8'h6A);
        check("R3 load priority", reg_a, 8'h6A);
        step(1'b0, 1'b1, 3'd5, 8'hFF, '0, 8'h00);
        check("R2 hold a", reg_a, 8'h6A);
        check("R2 hold zero", {7'd0, zero}, 8'h00);
        step(1'b1, 1'b0, 3'd0, 8'hFF, '0, '0);
        check("R13 unused code", reg_a, 8'h6A);
    endtask

    task automatic t_selective;
        step(1'b1, 1'b0, 3'd1, 8'hF0, '0, '0);
        check("R4 set", reg_a, 8'hFA);
        step(1'b1, 1'b0, 3'd2, 8'hF0, '0, '0);
        check("R5 toggle", reg_a, 8'h0A);
        step(1'b1, 1'b0, 3'd3, 8'h0F, '0, '0);
        check("R6 clear", reg_a, 8'h00);
        check("R12 zero after clear", {7'd0, zero}, 8'h01);
        load(8'h6A);
        step(1'b1, 1'b0, 3'd4, 8'hF0, '0, '0);
        check("R7 mask", reg_a, 8'h60);
        check("R12 zero after mask", {7'd0, zero}, 8'h00);
        step(1'b1, 1'b0, 3'd5, 8'h3C, '0, '0);
        check("R8 invert", reg_a, 8'h9F);
    endtask

    task automatic t_insert;
        load(8'h6A);
        step(1'b1, 1'b0, 3'd6, 8'h0F, 8'h9F, '0);
        check("R9 mask step", reg_a, 8'h0A);
        check("R9 busy raised", {7'd0, busy}, 8'h01);
        step(1'b1, 1'b1, 3'd5, 8'h00, 8'hFF, 8'hFF);
        check("R9 or step", reg_a, 8'h9A);
        check("R10 busy dropped", {7'd0, busy}, 8'h00);
        step(1'b0, 1'b0, 3'd0, '0, '0, '0);
        check("R10 request ignored", reg_a, 8'h9A);
    endtask

    task automatic t_compare;
        load(8'h3C);
        step(1'b1, 1'b0, 3'd7, 8'h3C, '0, '0);
        check("R11 equal", reg_a, 8'h00);
        check("R11 zero equal", {7'd0, zero}, 8'h01);
        load(8'h3C);
        step(1'b1, 1'b0, 3'd7, 8'h3D, '0, '0);
        check("R11 differ", reg_a, 8'h01);
        check("R11 zero differ", {7'd0, zero}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_load_hold();
        t_selective();
        t_insert();
        t_compare();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule